// File: doc/BRIEF.md
# Vector Memory Fault-Deferring Sequencer

This block carries out the element accesses of one vector load or store, strided by element size or indexed through a per-element byte offset. It uses a single-outstanding memory port whose response can flag a page fault. In deferred mode a faulting element does not stop the instruction. Its bit is set in a failure set and the sequencer moves on. One completion pulse, with an exception flag if anything failed, closes the instruction.

Software reads the completion mask, fixes the missing pages and issues the same instruction again with that mask supplied. Only the elements still outstanding are then accessed. A precise mode is also provided. In precise mode the instruction stops at the first faulting element, so everything below it is done and nothing from it upward was executed.

Loaded data lands in an internal register array of up to MAX_VL entries. Stores take their data from that array, and a read port exposes the array.

Top module: `vmem_defer_seq`

## Requirements
- R1: After reset, busy_o, done_o, exc_o and req_valid_o are 0, fail_mask_o and cmask_o are all zero, and every register-array entry reads 0.
- R2: For a non-indexed access, element e uses address base + (e << esize). The esize codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R3: For an indexed access, element e uses address base + index_i[e*32 +: 32]. The index is an unscaled byte offset.
- R4: Elements with index at or above vl, and elements whose cmask_i bit is set when start_i arrives, issue no request. With vl of 0, or every element already marked, done_o still pulses, exc_o stays 0 and no request is made.
- R5: In deferred mode, a faulting response sets that element's bit in fail_mask_o and the instruction goes on. A good response sets that element's bit in cmask_o. Within 0..vl-1, each attempted element ends up in exactly one of the two sets.
- R6: done_o is a one-cycle pulse that comes after every element has been attempted. exc_o is high in that cycle exactly when fail_mask_o is non-zero. Both masks hold their values until the next start.
- R7: In precise mode (precise_i=1), a fault on element j ends the instruction at once. fail_mask_o then holds only bit j, cmask_o gains bits for the elements below j, and nothing above j is requested.
- R8: fault_idx_o gives the lowest set bit of fail_mask_o.
- R9: Suppose an instruction is re-run with cmask_i set to the cmask_o of the previous run. Then only the previously failed elements are requested, and once they succeed cmask_o covers 0..vl-1.
- R10: A load writes the response data, cut to the element size and zero-extended, into array entry e. A faulting element leaves its entry unchanged.
- R11: A store drives req_we_o=1 with req_wdata_o set to array entry e cut to the element size. A store does not change the array.
- R12: A request holds req_valid_o and req_addr_o steady until req_ready_i. Only one request is outstanding at a time. In the default build, elements are issued in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; taken only while idle |
| vl_i | input | $clog2(MAX_VL+1) | Vector length |
| base_i | input | AW | Base address |
| esize_i | input | 2 | Element size code (0:1B 1:2B 2:4B 3:8B) |
| indexed_i | input | 1 | Indexed addressing |
| precise_i | input | 1 | Precise mode select |
| store_i | input | 1 | 1 store, 0 load |
| cmask_i | input | MAX_VL | Elements already performed |
| index_i | input | MAX_VL*IDX_W | Per-element byte offsets |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Completion pulse |
| exc_o | output | 1 | Exception, valid with done_o |
| fail_mask_o | output | MAX_VL | Failed elements |
| cmask_o | output | MAX_VL | Completed elements |
| fault_idx_o | output | $clog2(MAX_VL) | Lowest failed element |
| req_valid_o | output | 1 | Memory request valid |
| req_ready_i | input | 1 | Memory request ready |
| req_addr_o | output | AW | Request address |
| req_we_o | output | 1 | Request is a write |
| req_size_o | output | 2 | Request size code |
| req_wdata_o | output | DW | Write data |
| rsp_valid_i | input | 1 | Response valid |
| rsp_data_i | input | DW | Read data |
| rsp_fault_i | input | 1 | Response page fault |
| rd_idx_i | input | $clog2(MAX_VL) | Register array read index |
| rd_data_o | output | DW | Register array read data |

## Verification
The bench re-runs a faulted instruction with the returned completion mask. A design that ignored the mask would issue requests for elements already done, and the request log would catch them. A store run that marks a faulting element as already done checks that skipped elements really make no access: a design that touched that element would raise a spurious exception. Precise runs with faults in the middle of the vector check where the instruction stops. A design that carried on past the fault would show extra requests and extra failure bits. A long ready stall checks that the request address is held. Register readback after every run catches loads written at the wrong width or written on faulting elements.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2,
      ST_FIN  = 2'd3
   } seq_state_t;

   // Keep-bits for an element of 1, 2, 4 or 8 bytes.
   function automatic logic [63:0] lane_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    lane_mask = 64'h0000_0000_0000_00FF;
         2'd1:    lane_mask = 64'h0000_0000_0000_FFFF;
         2'd2:    lane_mask = 64'h0000_0000_FFFF_FFFF;
         default: lane_mask = 64'hFFFF_FFFF_FFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/vseq_pick.sv
// Chooses one pending element. The ascending encoder always exists; the
// DESCEND variant adds a top-down encoder used unless force_asc is high.
module vseq_pick #(
   parameter int N       = 16,
   parameter bit DESCEND = 1'b0,
   localparam int EIW    = $clog2(N)
) (
   input  logic [N-1:0]   pend,
   input  logic           force_asc,
   output logic           valid,
   output logic [EIW-1:0] idx
);
   logic [EIW-1:0] asc_idx;
   logic [EIW-1:0] dsc_idx;

   always_comb begin
      asc_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) asc_idx = EIW'(i);
      end
   end

   generate
      if (DESCEND) begin : g_desc
         always_comb begin
            dsc_idx = '0;
            for (int i = 0; i < N; i++) begin
               if (pend[i]) dsc_idx = EIW'(i);
            end
         end
      end else begin : g_asc_only
         assign dsc_idx = asc_idx;
      end
   endgenerate

   assign valid = |pend;
   assign idx   = force_asc ? asc_idx : dsc_idx;
endmodule

// File: rtl/vseq_agen.sv
// Element address: base plus either a scaled element number or a byte index.
module vseq_agen #(
   parameter int N     = 16,
   parameter int AW    = 32,
   parameter int IDX_W = 32,
   localparam int EIW  = $clog2(N)
) (
   input  logic [AW-1:0]      base,
   input  logic [1:0]         esize,
   input  logic               indexed,
   input  logic [N*IDX_W-1:0] idx_vec,
   input  logic [EIW-1:0]     elem,
   output logic [AW-1:0]      addr
);
   logic [IDX_W-1:0] idx_sel;
   logic [AW-1:0]    stride_off;
   logic [AW-1:0]    offset;

   assign idx_sel    = idx_vec[elem*IDX_W +: IDX_W];
   assign stride_off = AW'(elem) << esize;
   assign offset     = indexed ? AW'(idx_sel) : stride_off;
   assign addr       = base + offset;
endmodule

// File: rtl/vseq_regfile.sv
// Element data array: one write port, two combinational read ports.
module vseq_regfile #(
   parameter int N    = 16,
   parameter int DW   = 64,
   localparam int EIW = $clog2(N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [EIW-1:0] waddr,
   input  logic [DW-1:0]  wdata,
   input  logic [EIW-1:0] raddr_a,
   output logic [DW-1:0]  rdata_a,
   input  logic [EIW-1:0] raddr_b,
   output logic [DW-1:0]  rdata_b
);
   logic [DW-1:0] mem_q [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   assign rdata_a = mem_q[raddr_a];
   assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/vmem_defer_seq.sv
module vmem_defer_seq
   import vseq_pkg::*;
#(
   parameter int MAX_VL        = 16,
   parameter int AW            = 32,
   parameter int DW            = 64,
   parameter int IDX_W         = 32,
   parameter bit DEFER_DESCEND = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic [$clog2(MAX_VL+1)-1:0]   vl_i,
   input  logic [AW-1:0]                 base_i,
   input  logic [1:0]                    esize_i,
   input  logic                          indexed_i,
   input  logic                          precise_i,
   input  logic                          store_i,
   input  logic [MAX_VL-1:0]             cmask_i,
   input  logic [MAX_VL*IDX_W-1:0]       index_i,
   output logic                          busy_o,
   output logic                          done_o,
   output logic                          exc_o,
   output logic [MAX_VL-1:0]             fail_mask_o,
   output logic [MAX_VL-1:0]             cmask_o,
   output logic [$clog2(MAX_VL)-1:0]     fault_idx_o,
   output logic                          req_valid_o,
   input  logic                          req_ready_i,
   output logic [AW-1:0]                 req_addr_o,
   output logic                          req_we_o,
   output logic [1:0]                    req_size_o,
   output logic [DW-1:0]                 req_wdata_o,
   input  logic                          rsp_valid_i,
   input  logic [DW-1:0]                 rsp_data_i,
   input  logic                          rsp_fault_i,
   input  logic [$clog2(MAX_VL)-1:0]     rd_idx_i,
   output logic [DW-1:0]                 rd_data_o
);
   localparam int VLW = $clog2(MAX_VL + 1);
   localparam int EIW = $clog2(MAX_VL);

   // Elaboration-time parameter checks
   if (MAX_VL < 2 || MAX_VL > 64) begin : g_bad_vl
      $error("vmem_defer_seq: MAX_VL must lie in 2..64");
   end
   if (DW < 64) begin : g_bad_dw
      $error("vmem_defer_seq: DW must hold an 8-byte element");
   end
   if (IDX_W > AW) begin : g_bad_idx
      $error("vmem_defer_seq: IDX_W must not exceed AW");
   end

   seq_state_t               state_q;
   logic [VLW-1:0]           vl_q;
   logic [AW-1:0]            base_q;
   logic [1:0]               esize_q;
   logic                     indexed_q;
   logic                     precise_q;
   logic                     store_q;
   logic [MAX_VL*IDX_W-1:0]  index_q;
   logic [MAX_VL-1:0]        cmask_q;
   logic [MAX_VL-1:0]        fail_q;
   logic [MAX_VL-1:0]        tried_q;
   logic [EIW-1:0]           cur_q;

   logic [MAX_VL-1:0]        in_len;
   logic [MAX_VL-1:0]        pend;
   logic                     pick_vld;
   logic [EIW-1:0]           pick_idx;
   logic [AW-1:0]            elem_addr;
   logic [DW-1:0]            keep;
   logic [DW-1:0]            st_data;
   logic                     wb_en;
   logic                     fail_any;
   logic [EIW-1:0]           fail_low;

   // Elements below the latched vector length
   for (genvar e = 0; e < MAX_VL; e++) begin : g_len
      assign in_len[e] = (VLW'(e) < vl_q);
   end

   assign pend = in_len & ~cmask_q & ~tried_q;
   assign keep = DW'(lane_mask(esize_q));

   vseq_pick #(.N(MAX_VL), .DESCEND(DEFER_DESCEND)) u_pick (
      .pend      (pend),
      .force_asc (precise_q),
      .valid     (pick_vld),
      .idx       (pick_idx)
   );

   vseq_pick #(.N(MAX_VL), .DESCEND(1'b0)) u_fail_enc (
      .pend      (fail_q),
      .force_asc (1'b1),
      .valid     (fail_any),
      .idx       (fail_low)
   );

   vseq_agen #(.N(MAX_VL), .AW(AW), .IDX_W(IDX_W)) u_agen (
      .base    (base_q),
      .esize   (esize_q),
      .indexed (indexed_q),
      .idx_vec (index_q),
      .elem    (pick_idx),
      .addr    (elem_addr)
   );

   assign wb_en = (state_q == ST_WAIT) && rsp_valid_i && !rsp_fault_i && !store_q;

   vseq_regfile #(.N(MAX_VL), .DW(DW)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wb_en),
      .waddr   (cur_q),
      .wdata   (rsp_data_i & keep),
      .raddr_a (pick_idx),
      .rdata_a (st_data),
      .raddr_b (rd_idx_i),
      .rdata_b (rd_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         vl_q      <= '0;
         base_q    <= '0;
         esize_q   <= '0;
         indexed_q <= 1'b0;
         precise_q <= 1'b0;
         store_q   <= 1'b0;
         index_q   <= '0;
         cmask_q   <= '0;
         fail_q    <= '0;
         tried_q   <= '0;
         cur_q     <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  vl_q      <= vl_i;
                  base_q    <= base_i;
                  esize_q   <= esize_i;
                  indexed_q <= indexed_i;
                  precise_q <= precise_i;
                  store_q   <= store_i;
                  index_q   <= index_i;
                  cmask_q   <= cmask_i;
                  fail_q    <= '0;
                  tried_q   <= '0;
                  state_q   <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (!pick_vld) begin
                  state_q <= ST_FIN;
               end else if (req_ready_i) begin
                  cur_q   <= pick_idx;
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (rsp_valid_i) begin
                  tried_q[cur_q] <= 1'b1;
                  if (rsp_fault_i) begin
                     fail_q[cur_q] <= 1'b1;
                     state_q       <= precise_q ? ST_FIN : ST_REQ;
                  end else begin
                     cmask_q[cur_q] <= 1'b1;
                     state_q        <= ST_REQ;
                  end
               end
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = (state_q == ST_FIN);
   assign exc_o       = done_o && fail_any;
   assign fail_mask_o = fail_q;
   assign cmask_o     = cmask_q;
   assign fault_idx_o = fail_any ? fail_low : '0;

   assign req_valid_o = (state_q == ST_REQ) && pick_vld;
   assign req_addr_o  = elem_addr;
   assign req_we_o    = store_q;
   assign req_size_o  = esize_q;
   assign req_wdata_o = st_data & keep;
endmodule

// File: rtl/vmem_defer_seq_chk.sv
module vmem_defer_seq_chk #(
   parameter int MAX_VL = 16,
   parameter int AW     = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              done_o,
   input logic              exc_o,
   input logic [MAX_VL-1:0] fail_mask_o,
   input logic [MAX_VL-1:0] cmask_o,
   input logic              req_valid_o,
   input logic              req_ready_i,
   input logic [AW-1:0]     req_addr_o,
   input logic              precise_q
);
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_exc_only_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      exc_o |-> done_o);

   p_exc_iff_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (exc_o == (fail_mask_o != '0)));

   p_sets_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((fail_mask_o & cmask_o) == '0));

   p_precise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && precise_q) |-> ($countones(fail_mask_o) <= 1));

   p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

   p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && req_ready_i) |=> !req_valid_o);

   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !req_valid_o);
endmodule

bind vmem_defer_seq vmem_defer_seq_chk #(.MAX_VL(MAX_VL), .AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .exc_o       (exc_o),
   .fail_mask_o (fail_mask_o),
   .cmask_o     (cmask_o),
   .req_valid_o (req_valid_o),
   .req_ready_i (req_ready_i),
   .req_addr_o  (req_addr_o),
   .precise_q   (precise_q)
);

// File: tb/vmem_defer_seq_bench.sv
module vmem_defer_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BASE = 32'h0000_2000;

   typedef struct packed {
      logic [4:0]  vl;
      logic [1:0]  esz;
      logic        idx;
      logic        prc;
      logic        st;
      logic [15:0] cm;
      logic [31:0] flo;
      logic [31:0] fhi;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t TBL [NVEC] = '{
      '{5'd16, 2'd3, 1'b0, 1'b0, 1'b0, 16'h0000, 32'h0,      32'h0},
      '{5'd16, 2'd2, 1'b0, 1'b0, 1'b0, 16'h0000, 32'h2010,   32'h2020},
      '{5'd5,  2'd0, 1'b0, 1'b1, 1'b0, 16'h0000, 32'h2002,   32'h2003},
      '{5'd8,  2'd1, 1'b1, 1'b0, 1'b0, 16'h0000, 32'h0,      32'h0},
      '{5'd0,  2'd3, 1'b0, 1'b0, 1'b0, 16'h0000, 32'h2000,   32'h3000},
      '{5'd16, 2'd3, 1'b0, 1'b0, 1'b0, 16'hFFFF, 32'h2000,   32'h3000},
      '{5'd10, 2'd3, 1'b1, 1'b1, 1'b0, 16'h0000, 32'h20C0,   32'h20D0},
      '{5'd6,  2'd2, 1'b0, 1'b0, 1'b1, 16'h0005, 32'h2008,   32'h200C},
      '{5'd4,  2'd1, 1'b0, 1'b0, 1'b1, 16'h0000, 32'h2002,   32'h2004}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [4:0]  vl_i = '0;
   logic [31:0] base_i = BASE;
   logic [1:0]  esize_i = '0;
   logic        indexed_i = 1'b0;
   logic        precise_i = 1'b0;
   logic        store_i = 1'b0;
   logic [15:0] cmask_i = '0;
   logic [511:0] index_i = '0;
   logic        busy_o, done_o, exc_o;
   logic [15:0] fail_mask_o, cmask_o;
   logic [3:0]  fault_idx_o;
   logic        req_valid_o;
   logic        req_ready_i = 1'b1;
   logic [31:0] req_addr_o;
   logic        req_we_o;
   logic [1:0]  req_size_o;
   logic [63:0] req_wdata_o;
   logic        rsp_valid_i = 1'b0;
   logic [63:0] rsp_data_i = '0;
   logic        rsp_fault_i = 1'b0;
   logic [3:0]  rd_idx_i = '0;
   logic [63:0] rd_data_o;

   int n_checks = 0;
   int n_errors = 0;

   // memory model state
   logic [31:0] flt_lo = '0, flt_hi = '0;
   int          log_n = 0;
   logic [31:0] log_addr [64];
   logic        log_we   [64];
   logic [63:0] log_wd   [64];
   logic        have_req = 1'b0;
   logic [31:0] pend_addr = '0;

   logic [63:0] shadow [16];

   vmem_defer_seq u_vmem_defer_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i), .base_i(base_i),
      .esize_i(esize_i), .indexed_i(indexed_i), .precise_i(precise_i),
      .store_i(store_i), .cmask_i(cmask_i), .index_i(index_i),
      .busy_o(busy_o), .done_o(done_o), .exc_o(exc_o), .fail_mask_o(fail_mask_o),
      .cmask_o(cmask_o), .fault_idx_o(fault_idx_o), .req_valid_o(req_valid_o),
      .req_ready_i(req_ready_i), .req_addr_o(req_addr_o), .req_we_o(req_we_o),
      .req_size_o(req_size_o), .req_wdata_o(req_wdata_o), .rsp_valid_i(rsp_valid_i),
      .rsp_data_i(rsp_data_i), .rsp_fault_i(rsp_fault_i), .rd_idx_i(rd_idx_i),
      .rd_data_o(rd_data_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [63:0] mem_data(input logic [31:0] a);
      return {~a, a};
   endfunction

   function automatic logic [63:0] smask(input logic [1:0] sz);
      case (sz)
         2'd0: return 64'hFF;
         2'd1: return 64'hFFFF;
         2'd2: return 64'hFFFF_FFFF;
         default: return '1;
      endcase
   endfunction

   function automatic logic [31:0] idx_val(input int e);
      return 32'((15 - e) * 16 + 4);
   endfunction

   function automatic logic [31:0] exp_addr(input vec_t v, input int e);
      if (v.idx) return BASE + idx_val(e);
      return BASE + (32'(e) << v.esz);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Memory model: accept, answer one cycle later, then drop the response.
   initial begin
      forever begin
         @(negedge clk);
         if (rsp_valid_i) rsp_valid_i = 1'b0;
         if (have_req) begin
            rsp_valid_i = 1'b1;
            rsp_fault_i = (pend_addr >= flt_lo) && (pend_addr < flt_hi);
            rsp_data_i  = mem_data(pend_addr);
            have_req    = 1'b0;
         end else if (req_valid_o && req_ready_i) begin
            have_req  = 1'b1;
            pend_addr = req_addr_o;
            if (log_n < 64) begin
               log_addr[log_n] = req_addr_o;
               log_we[log_n]   = req_we_o;
               log_wd[log_n]   = req_wdata_o;
            end
            log_n++;
         end
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   task automatic do_op(input vec_t v, input int stall, input string tag);
      logic [15:0] e_fail;
      logic [15:0] e_cm;
      int          e_n;
      logic [31:0] e_addr [16];
      logic [63:0] e_wd [16];
      logic        e_stop;
      logic [3:0]  e_low;
      int          waited;
      e_fail = '0; e_cm = v.cm; e_n = 0; e_stop = 1'b0; e_low = '0;
      for (int e = 0; e < 16; e++) begin
         if (!e_stop && e < int'(v.vl) && !v.cm[e]) begin
            logic [31:0] a;
            a = exp_addr(v, e);
            e_addr[e_n] = a;
            e_wd[e_n]   = v.st ? (shadow[e] & smask(v.esz)) : 64'h0;
            e_n++;
            if (a >= v.flo && a < v.fhi) begin
               e_fail[e] = 1'b1;
               if (v.prc) e_stop = 1'b1;
            end else begin
               e_cm[e] = 1'b1;
               if (!v.st) shadow[e] = mem_data(a) & smask(v.esz);
            end
         end
      end
      for (int e = 15; e >= 0; e--) if (e_fail[e]) e_low = 4'(e);

      @(negedge clk);
      log_n = 0;
      flt_lo = v.flo; flt_hi = v.fhi;
      vl_i = v.vl; esize_i = v.esz; indexed_i = v.idx; precise_i = v.prc;
      store_i = v.st; cmask_i = v.cm;
      if (stall > 0) req_ready_i = 1'b0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (stall > 0) begin
         repeat (stall) @(negedge clk);
         check("R12", {tag, " held valid"}, 64'(req_valid_o), 64'd1);
         check("R12", {tag, " held addr"}, 64'(req_addr_o), 64'(e_addr[0]));
         check("R12", {tag, " no accept"}, 64'(log_n), 64'd0);
         @(posedge clk);
         #1 req_ready_i = 1'b1;
      end
      waited = 0;
      while (!done_o && waited < 400) begin
         @(negedge clk);
         waited++;
      end
      check("R6", {tag, " done"}, 64'(done_o), 64'd1);
      check("R6", {tag, " exc"}, 64'(exc_o), 64'(e_fail != 16'h0));
      check(v.prc ? "R7" : "R5", {tag, " fail mask"}, 64'(fail_mask_o), 64'(e_fail));
      check(v.prc ? "R7" : "R5", {tag, " cmask"}, 64'(cmask_o), 64'(e_cm));
      check("R4", {tag, " request count"}, 64'(log_n), 64'(e_n));
      if (e_fail != 16'h0)
         check("R8", {tag, " fault idx"}, 64'(fault_idx_o), 64'(e_low));
      for (int k = 0; k < e_n && k < log_n; k++) begin
         check(v.idx ? "R3" : "R2", {tag, " addr/order R12"}, 64'(log_addr[k]), 64'(e_addr[k]));
         check(v.st ? "R11" : "R10", {tag, " we"}, 64'(log_we[k]), 64'(v.st));
         if (v.st) check("R11", {tag, " wdata"}, log_wd[k], e_wd[k]);
      end
      @(negedge clk);
      check("R6", {tag, " pulse ends"}, 64'(done_o), 64'd0);
      check("R6", {tag, " masks held"}, 64'({fail_mask_o, cmask_o}), 64'({e_fail, e_cm}));
      for (int r = 0; r < 16; r++) begin
         rd_idx_i = 4'(r);
         #1;
         check(v.st ? "R11" : "R10", {tag, " array"}, rd_data_o, shadow[r]);
      end
   endtask

   initial begin
      vec_t rv;
      for (int e = 0; e < 16; e++) begin
         index_i[e*32 +: 32] = idx_val(e);
         shadow[e] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", "busy", 64'(busy_o), 64'd0);
      check("R1", "done/exc", 64'({done_o, exc_o}), 64'd0);
      check("R1", "req_valid", 64'(req_valid_o), 64'd0);
      check("R1", "masks", 64'({fail_mask_o, cmask_o}), 64'd0);
      rd_idx_i = 4'd7;
      #1;
      check("R1", "array entry", rd_data_o, 64'd0);

      // Table walk
      for (int t = 0; t < NVEC; t++) begin
         do_op(TBL[t], 0, $sformatf("vec%0d", t));
      end

      // R9: deferred fault then re-run with the returned completion mask
      do_op(TBL[1], 0, "R9 first");
      check("R9", "mask after fault", 64'(cmask_o), 64'h0000_0000_0000_FF0F);
      rv = TBL[1];
      rv.cm = cmask_o;
      rv.flo = '0;
      rv.fhi = '0;
      do_op(rv, 0, "R9 rerun");
      check("R9", "rerun requests", 64'(log_n), 64'd4);
      check("R9", "rerun mask", 64'(cmask_o), 64'h0000_0000_0000_FFFF);

      // R12: ready held low for several cycles
      rv = TBL[0];
      rv.vl = 5'd2;
      do_op(rv, 4, "R12 stall");

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule